// File: doc/BRIEF.md
# Programmable Periodic Event Divider

This block divides a 32.768 kHz time base, delivered as a one-cycle tick enable in the system clock domain, into a periodic event. A 4-bit rate code picks a power-of-two period. On each event the block raises a one-cycle strobe toward the interrupt logic when the periodic enable is set, and a one-cycle pulse on the square-wave pin when the square-wave enable is set. Flag registers and interrupt generation sit outside this block.

A free-running 15-bit tick counter starts at zero on reset and advances on every tick, whatever the enables are. An event falls on the tick that brings the counter to a multiple of the selected period. Events therefore stay on the same grid however the rate code or the enables change. A small state machine turns each event into the registered output pulses. Its states are OFF (divider stopped: the rate code is zero or both enables are low), ARMED (divider running, waiting for a boundary) and EVENT (the one cycle in which the pulses are driven). Its transitions are: any state goes to OFF when the divider is not active; any state goes to EVENT when the divider is active and a boundary tick arrives; any other active cycle goes to ARMED.

Top module: `periodic_rate_div`

## Requirements
- R1: For rate codes 3 to 15 the event period is 2^(code-1) ticks, from 4 ticks (code 3) to 16384 ticks (code 15).
- R2: Rate code 0 stops the divider. Neither output pulses while it is selected.
- R3: Rate code 1 gives the same period as code 8 (128 ticks), and rate code 2 gives the same period as code 9 (256 ticks).
- R4: The tick counter is 15 bits wide, is zero after reset and counts every tick whatever the enables are. An event occurs on a tick that brings the counter to a multiple of the period.
- R5: When the periodic enable and the square-wave enable are both 0, the divider is stopped and neither output pulses.
- R6: `per_strobe` is high for exactly one cycle per event, and only when `per_en` was 1 on the event tick.
- R7: `sqw_pulse` is a one-cycle pulse per event, and only when `sqw_en` was 1 on the event tick. It is not a 50% duty-cycle wave.
- R8: After a rate-code change the next event falls on the next boundary of the new period. No extra pulse appears at the change.
- R9: An output pulse appears in the cycle after the clock edge that samples the event tick. Without a tick there is no event.
- R10: During reset and in the first cycle after it both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| rate_code | input | 4 | Rate select; 0 stops the divider |
| per_en | input | 1 | Periodic strobe enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| per_strobe | output | 1 | One-cycle periodic event strobe |
| sqw_pulse | output | 1 | One-cycle pulse for the square-wave pin |

## Verification
Each result is due exactly one cycle after the edge that samples the event tick. The bench's reference model runs at the same rising edge: it counts ticks modulo 32768 and decides whether a boundary was hit with a modulo on the period, not a bit mask. It queues the expected output pair, and the monitor pops and compares it at the next falling edge. Inputs change 1 ns after a rising edge, so model and design always see the same values. Windows whose tick count is a whole number of periods are also checked for an exact pulse count, because such a window holds exactly one event per period wherever the grid happens to start.

// File: rtl/prd_pkg.sv
package prd_pkg;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 15;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ARMED,
        ST_EVENT
    } prd_state_e;

    // Codes 1 and 2 alias onto the longer periods of codes 8 and 9.
    function automatic logic [CODE_W-1:0] alias_code(input logic [CODE_W-1:0] c);
        if (c == CODE_W'(1)) return CODE_W'(8);
        if (c == CODE_W'(2)) return CODE_W'(9);
        return c;
    endfunction
endpackage

// File: rtl/prd_rate_decode.sv
module prd_rate_decode #(
    parameter int CODE_W = prd_pkg::CODE_W,
    parameter int CNT_W  = prd_pkg::CNT_W
) (
    input  logic [CODE_W-1:0] rate_code,
    output logic [CNT_W-1:0]  low_mask,
    output logic              rate_on
);
    logic [CODE_W-1:0] eff;

    always_comb begin
        eff     = prd_pkg::alias_code(rate_code);
        rate_on = (rate_code != '0);
    end

    // Bit i takes part in the boundary test when i < eff-1.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign low_mask[i] = (i < (int'(eff) - 1));
    end
endmodule

// File: rtl/prd_tick_counter.sv
module prd_tick_counter #(
    parameter int CNT_W = prd_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_next
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt_next = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_next;
    end
endmodule

// File: rtl/prd_event_fsm.sv
module prd_event_fsm
    import prd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hit,
    input  logic per_en,
    input  logic sqw_en,
    output logic per_strobe,
    output logic sqw_pulse
);
    prd_state_e state_q, state_d;
    logic       per_fl_q, sqw_fl_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF, ST_ARMED, ST_EVENT: begin
                if (!active)  state_d = ST_OFF;
                else if (hit) state_d = ST_EVENT;
                else          state_d = ST_ARMED;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            per_fl_q <= 1'b0;
            sqw_fl_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_EVENT) begin
                per_fl_q <= per_en;
                sqw_fl_q <= sqw_en;
            end
        end
    end

    always_comb begin
        per_strobe = 1'b0;
        sqw_pulse  = 1'b0;
        unique case (state_q)
            ST_EVENT: begin
                per_strobe = per_fl_q;
                sqw_pulse  = sqw_fl_q;
            end
            ST_OFF, ST_ARMED: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/periodic_rate_div.sv
module periodic_rate_div #(
    parameter int CODE_W = prd_pkg::CODE_W,
    parameter int CNT_W  = prd_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              per_en,
    input  logic              sqw_en,
    output logic              per_strobe,
    output logic              sqw_pulse
);
    logic [CNT_W-1:0] low_mask;
    logic [CNT_W-1:0] cnt_next;
    logic             rate_on;
    logic             active;
    logic             hit;

    prd_rate_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
        .rate_code (rate_code),
        .low_mask  (low_mask),
        .rate_on   (rate_on)
    );

    prd_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_32k),
        .cnt_next (cnt_next)
    );

    assign active = rate_on && (per_en || sqw_en);
    assign hit    = tick_32k && ((cnt_next & low_mask) == '0);

    prd_event_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .hit        (hit),
        .per_en     (per_en),
        .sqw_en     (sqw_en),
        .per_strobe (per_strobe),
        .sqw_pulse  (sqw_pulse)
    );
endmodule

// File: rtl/prd_checker.sv
module prd_checker #(
    parameter int CODE_W = prd_pkg::CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_32k,
    input logic [CODE_W-1:0] rate_code,
    input logic              per_en,
    input logic              sqw_en,
    input logic              per_strobe,
    input logic              sqw_pulse
);
    AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code == '0) |=> (!per_strobe && !sqw_pulse)); // R2
    AST_BOTH_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_en && !sqw_en) |=> (!per_strobe && !sqw_pulse)); // R5
    AST_PER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !per_en |=> !per_strobe); // R6
    AST_PER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        per_strobe |=> !per_strobe); // R6
    AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_en |=> !sqw_pulse); // R7
    AST_SQW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_pulse |=> !sqw_pulse); // R7
    AST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_32k |=> (!per_strobe && !sqw_pulse)); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!per_strobe && !sqw_pulse)); // R10
endmodule

bind periodic_rate_div prd_checker #(.CODE_W(CODE_W)) u_prd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_32k   (tick_32k),
    .rate_code  (rate_code),
    .per_en     (per_en),
    .sqw_en     (sqw_en),
    .per_strobe (per_strobe),
    .sqw_pulse  (sqw_pulse)
);

// File: tb/periodic_rate_div_bench.sv
module periodic_rate_div_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       per_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic       per_strobe, sqw_pulse;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    per_total = 0;
    int    sqw_total = 0;
    bit    done = 1'b0;
    string tag = "R10";

    logic [1:0] exp_q[$];
    int         mcnt = 0;

    always #2 clk = ~clk;

    periodic_rate_div u_periodic_rate_div (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_code(rate_code),
        .per_en(per_en), .sqw_en(sqw_en),
        .per_strobe(per_strobe), .sqw_pulse(sqw_pulse)
    );

    function automatic int period_of(input logic [3:0] c);
        int e;
        e = (c == 4'd1) ? 8 : (c == 4'd2) ? 9 : int'(c);
        return 1 << (e - 1);
    endfunction

    // Driver-side reference model: predicts the outputs due one cycle later.
    always @(posedge clk) begin
        if (rst_n) begin
            bit act, hit;
            int nxt;
            nxt = (mcnt + 1) % 32768;
            act = (rate_code != 4'd0) && (per_en || sqw_en);
            hit = tick_32k && act && ((nxt % period_of(rate_code)) == 0);
            exp_q.push_back({hit && per_en, hit && sqw_en});
            if (tick_32k) mcnt = nxt;
        end
    end

    // Monitor: pops each expectation at the falling edge after it was queued.
    always @(negedge clk) begin
        if (exp_q.size() > 0 && !done) begin
            logic [1:0] e;
            e = exp_q.pop_front();
            n_tests++;
            if ({per_strobe, sqw_pulse} !== e) begin
                n_fail++;
                $display("FAIL %s per/sqw got %b%b expected %b%b at %0t",
                         tag, per_strobe, sqw_pulse, e[1], e[0], $time);
            end
            if (per_strobe) per_total++;
            if (sqw_pulse)  sqw_total++;
        end
    end

    task automatic check_eq(input string r, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0d expected %0d", r, what, act, exp);
        end
    endtask

    task automatic run_window(input string r, input logic [3:0] c, input bit pe, input bit se,
                              input int n, input int tdiv, output int per_n, output int sqw_n);
        int p0, s0;
        @(posedge clk); #1;
        tag = r; rate_code = c; per_en = pe; sqw_en = se;
        p0 = per_total; s0 = sqw_total;
        for (int k = 0; k < n; k++) begin
            tick_32k = ((k % tdiv) == 0);
            @(posedge clk); #1;
        end
        tick_32k = 1'b0;
        @(negedge clk); #1;
        per_n = per_total - p0;
        sqw_n = sqw_total - s0;
    endtask

    initial begin
        int pn, sn;
        repeat (3) begin
            @(negedge clk);
            check_eq("R10", "outputs in reset", int'(per_strobe) + int'(sqw_pulse), 0);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;

        run_window("R1", 4'd6, 1, 0, 320, 1, pn, sn);
        check_eq("R1", "strobes code 6 over 320 ticks", pn, 10);
        run_window("R2", 4'd0, 1, 1, 200, 1, pn, sn);
        check_eq("R2", "strobes with code 0", pn + sn, 0);
        run_window("R3", 4'd1, 1, 0, 1024, 1, pn, sn);
        check_eq("R3", "strobes code 1 over 1024 ticks", pn, 8);
        run_window("R3", 4'd2, 1, 0, 1024, 1, pn, sn);
        check_eq("R3", "strobes code 2 over 1024 ticks", pn, 4);
        run_window("R5", 4'd4, 0, 0, 200, 1, pn, sn);
        check_eq("R5", "pulses with both enables low", pn + sn, 0);
        run_window("R7", 4'd5, 0, 1, 160, 1, pn, sn);
        check_eq("R7", "sqw pulses code 5 over 160 ticks", sn, 10);
        check_eq("R6", "strobes with per_en low", pn, 0);
        run_window("R6", 4'd3, 1, 1, 40, 1, pn, sn);
        check_eq("R6", "strobes code 3 over 40 ticks", pn, 10);
        run_window("R9", 4'd3, 1, 0, 120, 3, pn, sn);
        check_eq("R9", "strobes with 40 sparse ticks", pn, 10);
        run_window("R8", 4'd7, 1, 0, 50, 1, pn, sn);
        run_window("R8", 4'd3, 1, 0, 40, 1, pn, sn);
        check_eq("R8", "strobes after rate change", pn, 10);
        run_window("R4", 4'd9, 1, 1, 700, 1, pn, sn);
        check_eq("R4", "sqw equals per on shared grid", sn, pn);
        run_window("R1", 4'd15, 1, 0, 16384, 1, pn, sn);
        check_eq("R1", "strobes code 15 over 16384 ticks", pn, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired in %s", tag);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule